// File: doc/BRIEF.md
# Write-Only Two-Wire Command Register Slave

This block sits on a two-wire serial bus (I2C) as a slave that only accepts writes. It oversamples the bus clock and data lines with a fast system clock. It recognises its own 7-bit address, which is formed from a fixed 5-bit prefix and two strap inputs. It then takes one command byte. Three command codes each name a destination register, and the byte that follows the command is written into that register.

A register is written only after the data byte and its acknowledge clock have both completed. A START or STOP that arrives earlier ends the transfer without touching any register. The three registers are visible on output ports at all times. A one-cycle strobe marks every committed write. The block acknowledges a byte by asserting an open-drain pull-down enable for one bus clock period.

Top module: `i2cw_slave`

## Requirements
- R1: The block acknowledges an address byte only when its first seven bits, sent most significant first, equal `10010` followed by `strap_i[1]` and `strap_i[0]`, and its eighth bit (read/write) is 0.
- R2: `sda_oe` is raised and dropped only while the bus clock is low. When raised, it stays asserted through the entire high phase of the ninth clock of a byte.
- R3: After a matched address, command byte 0x12 selects the frequency register, 0x14 selects the channel register and 0x10 selects the control register. These three bytes are acknowledged. Any other command byte is not acknowledged, and the byte that follows it changes no register.
- R4: The data byte after a valid command is acknowledged. It is loaded into the selected register when the falling bus clock edge ends its acknowledge. `wr_stb` is high for exactly one system clock cycle in the same cycle as that load.
- R5: A STOP or START that arrives before the data byte's acknowledge has completed leaves all three registers unchanged and produces no `wr_stb`.
- R6: After a non-matching address or a read request, the block acknowledges nothing and writes nothing until the next START.
- R7: `strap_i` matters only while the two address bit positions it supplies are being received. Its value before or after those positions does not affect the address match.
- R8: After reset, `sda_oe` and `wr_stb` are 0 and all three registers read 0.
- R9: A START in any state restarts address reception, so a repeated START followed by a matching address is acknowledged.
- R10: A register output changes only in a cycle where `wr_stb` is high, and no more than one register changes per write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled from the pin |
| sda_i | input | 1 | Bus data line as sampled from the pin |
| strap_i | input | 2 | Low two address bits from board straps |
| sda_oe | output | 1 | Pull data line low when 1 (acknowledge) |
| freq_q | output | 8 | Frequency register |
| chan_q | output | 8 | Channel-selection register |
| ctrl_q | output | 8 | Control register |
| wr_stb | output | 1 | One-cycle pulse on each committed register write |

## Verification
Some properties hold on every cycle and are checked there: the acknowledge enable moves only while the bus clock is low, the write strobe never lasts longer than one cycle, and a register changes only under the strobe, one register at a time. Other behaviour depends on a whole bus transaction, so only the bench scenarios can show it. This covers which address and command bytes earn an acknowledge, the value each register ends up holding, the cancelling effect of an early STOP or repeated START, and the window in which the straps are sampled.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int STRAP_W = 2;
    localparam int FIX_W   = ADDR_W - STRAP_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int POS_W   = $clog2(BYTE_W);
    localparam int NUM_REGS = 3;
    localparam int IDX_W   = $clog2(NUM_REGS);

    localparam logic [FIX_W-1:0]  ADDR_FIXED = 5'b10010;
    localparam logic [BYTE_W-1:0] CMD_FREQ   = 8'h12;
    localparam logic [BYTE_W-1:0] CMD_CHAN   = 8'h14;
    localparam logic [BYTE_W-1:0] CMD_CTRL   = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_DATA, ST_DATA_ACK, ST_IGNORE
    } phase_e;

    // index order is also the register-bank order
    typedef enum logic [IDX_W-1:0] {
        TGT_FREQ = 2'd0, TGT_CHAN = 2'd1, TGT_CTRL = 2'd2, TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        logic valid;
        tgt_e tgt;
    } decode_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic decode_t decode_cmd(input logic [BYTE_W-1:0] c);
        decode_t d;
        d.valid = 1'b1;
        case (c)
            CMD_FREQ: d.tgt = TGT_FREQ;
            CMD_CHAN: d.tgt = TGT_CHAN;
            CMD_CTRL: d.tgt = TGT_CTRL;
            default: begin
                d.valid = 1'b0;
                d.tgt   = TGT_NONE;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond import i2cw_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs #(
    parameter int W  = 8,
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [IW-1:0]       sel,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] q,
    output logic                stb
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                              q[g] <= '0;
            else if (commit && sel == IW'(g))     q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stb <= 1'b0;
        else     stb <= commit;
    end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave import i2cw_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  freq_q,
    output logic [BYTE_W-1:0]  chan_q,
    output logic [BYTE_W-1:0]  ctrl_q,
    output logic               wr_stb
);
    logic [1:0] line_s;
    bus_ev_t    ev;

    i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
    );

    i2cw_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]), .ev(ev)
    );

    phase_e            st;
    logic [CNT_W-1:0]  bitn;
    logic [BYTE_W-1:0] shreg;
    logic              addr_ok;
    tgt_e              tgt;
    logic              oe;
    logic              commit;
    logic [BYTE_W-1:0] exp_byte;
    logic [POS_W-1:0]  pos;
    decode_t           dec;

    // expected address byte, straps read live at their own positions
    assign exp_byte = {ADDR_FIXED, strap_i, 1'b0};
    assign pos      = POS_W'(BYTE_W - 1) - bitn[POS_W-1:0];
    assign dec      = decode_cmd(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bitn    <= '0;
            shreg   <= '0;
            addr_ok <= 1'b0;
            tgt     <= TGT_NONE;
            oe      <= 1'b0;
            commit  <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (ev.stop) begin
                st <= ST_IDLE;
                oe <= 1'b0;
            end else if (ev.start) begin
                st      <= ST_ADDR;
                bitn    <= '0;
                addr_ok <= 1'b1;
                oe      <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_CMD, ST_DATA: begin
                        if (ev.scl_rise && bitn < CNT_W'(BYTE_W)) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            bitn  <= bitn + 1'b1;
                            if (st == ST_ADDR && ev.sda != exp_byte[pos])
                                addr_ok <= 1'b0;
                        end else if (ev.scl_fall && bitn == CNT_W'(BYTE_W)) begin
                            bitn <= '0;
                            if (st == ST_ADDR) begin
                                if (addr_ok) begin
                                    oe <= 1'b1;
                                    st <= ST_ADDR_ACK;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end else if (st == ST_CMD) begin
                                if (dec.valid) begin
                                    tgt <= dec.tgt;
                                    oe  <= 1'b1;
                                    st  <= ST_CMD_ACK;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end else begin
                                oe <= 1'b1;
                                st <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (ev.scl_fall) begin
                        oe <= 1'b0;
                        st <= ST_CMD;
                    end
                    ST_CMD_ACK: if (ev.scl_fall) begin
                        oe <= 1'b0;
                        st <= ST_DATA;
                    end
                    ST_DATA_ACK: if (ev.scl_fall) begin
                        oe     <= 1'b0;
                        commit <= 1'b1;
                        st     <= ST_IGNORE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe;

    logic [NUM_REGS-1:0][BYTE_W-1:0] rq;

    i2cw_regs #(.W(BYTE_W), .N(NUM_REGS), .IW(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .commit(commit), .sel(tgt),
        .wdata(shreg), .q(rq), .stb(wr_stb)
    );

    assign freq_q = rq[TGT_FREQ];
    assign chan_q = rq[TGT_CHAN];
    assign ctrl_q = rq[TGT_CTRL];
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] freq_q,
    input logic [7:0] chan_q,
    input logic [7:0] ctrl_q
);
    // R2
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R2
    oe_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_i);

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R10
    reg_only_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> ($stable(freq_q) && $stable(chan_q) && $stable(ctrl_q)));

    // R10
    one_reg_per_write_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({!$stable(freq_q), !$stable(chan_q), !$stable(ctrl_q)}) <= 1);
endmodule

bind i2cw_slave i2cw_chk u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .freq_q(freq_q), .chan_q(chan_q), .ctrl_q(ctrl_q)
);

// File: tb/sim_i2cw_slave.sv
module sim_i2cw_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'd0;
    logic       sda_oe, wr_stb;
    logic [7:0] freq_q, chan_q, ctrl_q;
    logic       sda_bus;

    int nchk = 0;
    int nfail = 0;
    int stb_cnt = 0;
    int exp_stb = 0;
    logic [7:0] e_freq = 8'h00, e_chan = 8'h00, e_ctrl = 8'h00;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cw_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
        .sda_oe(sda_oe), .freq_q(freq_q), .chan_q(chan_q), .ctrl_q(ctrl_q),
        .wr_stb(wr_stb)
    );

    always @(posedge clk) if (!rst && wr_stb) stb_cnt++;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_ack(output logic a);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        a = ~sda_bus;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_ack(a);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    function automatic bit cmd_ok(input logic [7:0] c);
        return (c == 8'h12) || (c == 8'h14) || (c == 8'h10);
    endfunction

    task automatic model_write(input logic [7:0] c, input logic [7:0] d);
        if (c == 8'h12) e_freq = d;
        if (c == 8'h14) e_chan = d;
        if (c == 8'h10) e_ctrl = d;
        exp_stb++;
    endtask

    task automatic check_regs(input string req);
        check({req, " freq"}, freq_q, e_freq);
        check({req, " chan"}, chan_q, e_chan);
        check({req, " ctrl"}, ctrl_q, e_ctrl);
        check({req, " strobes"}, stb_cnt, exp_stb);
    endtask

    task automatic addr_txn(input logic [7:0] ab, input bit exp_ack);
        logic a;
        do_start();
        send_byte(ab, a);
        check("R1 address ack", a, exp_ack);
        if (!exp_ack) begin
            send_byte(8'h12, a);
            check("R6 cmd ignored", a, 0);
            send_byte(8'h5A, a);
            check("R6 data ignored", a, 0);
        end
        do_stop();
        check_regs("R6/R5 no write");
    endtask

    task automatic full_write(input logic [7:0] ab, input logic [7:0] c, input logic [7:0] d);
        logic a;
        do_start();
        send_byte(ab, a);
        check("R1 address ack", a, 1);
        send_byte(c, a);
        check("R3 cmd ack", a, cmd_ok(c));
        send_byte(d, a);
        check("R4 data ack", a, cmd_ok(c));
        do_stop();
        if (cmd_ok(c)) model_write(c, d);
        check_regs("R4/R3 write");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic a;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R8 reset state
        check("R8 sda_oe", sda_oe, 0);
        check("R8 wr_stb", wr_stb, 0);
        check_regs("R8 reset");

        // R1 strap / low-bit / direction sweep (R6 on the misses)
        for (int s = 0; s < 4; s++)
            for (int lo = 0; lo < 4; lo++)
                for (int rw = 0; rw < 2; rw++) begin
                    strap = 2'(s);
                    addr_txn({5'b10010, 2'(lo), 1'(rw)}, (lo == s) && (rw == 0));
                end
        // R1 fixed-prefix sweep
        for (int hi = 0; hi < 32; hi++) begin
            strap = 2'd2;
            addr_txn({5'(hi), 2'b10, 1'b0}, hi == 18);
        end

        // R3 / R4 full command sweep
        strap = 2'd1;
        for (int c = 0; c < 256; c++) full_write(8'h92, 8'(c), 8'(c) ^ 8'hA5);

        // R4 / R10 boundary values to each register
        full_write(8'h92, 8'h12, 8'h00);
        full_write(8'h92, 8'h14, 8'hFF);
        full_write(8'h92, 8'h10, 8'h01);
        full_write(8'h92, 8'h12, 8'h80);

        // R5 STOP in the middle of the data byte
        do_start(); send_byte(8'h92, a); send_byte(8'h12, a);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        do_stop();
        check_regs("R5 stop mid-data");

        // R5 STOP right after command acknowledge
        do_start(); send_byte(8'h92, a); send_byte(8'h14, a);
        do_stop();
        check_regs("R5 stop after cmd");

        // R5 / R9 repeated START mid-data, then a full write
        do_start(); send_byte(8'h92, a); send_byte(8'h10, a);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        check_regs("R5 before restart");
        full_write(8'h92, 8'h10, 8'h3C);

        // R9 repeated START after a NACKed address
        do_start(); send_byte(8'h96, a);
        check("R9 wrong address nack", a, 0);
        do_start(); send_byte(8'h92, a);
        check("R9 restart ack", a, 1);
        send_byte(8'h14, a); send_byte(8'hC3, a);
        do_stop();
        model_write(8'h14, 8'hC3);
        check_regs("R9 write after restart");

        // R7 straps change after address: write still accepted
        strap = 2'd2;
        do_start(); send_byte(8'h94, a);
        check("R7 addr ack", a, 1);
        strap = 2'd1;
        send_byte(8'h12, a);
        check("R7 cmd ack after strap change", a, 1);
        send_byte(8'h6E, a);
        do_stop();
        model_write(8'h12, 8'h6E);
        check_regs("R7 write");

        // R7 straps only correct after the address: no ack
        strap = 2'd0;
        do_start();
        for (int i = 7; i >= 0; i--) send_bit(i == 7 || i == 4 || i == 2 || i == 1);
        strap = 2'd3;
        get_ack(a);
        check("R7 late strap nack", a, 0);
        do_stop();

        // R7 straps wrong during prefix, correct at their positions: ack
        strap = 2'd0;
        do_start();
        for (int i = 7; i >= 3; i--) send_bit(i == 7 || i == 4);
        strap = 2'd3;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        strap = 2'd0;
        get_ack(a);
        check("R7 strap window ack", a, 1);
        do_stop();
        check_regs("R7 no write");

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule